// File: doc/BRIEF.md
# Dual Event Counter with Power-Mode Control

The block counts rising edges on two external event pins, using one 8-bit counter for each pin. Each pin is brought into the clock domain, and an edge is accepted only if both the high phase and the low phase last long enough. The two counters can run as independent 8-bit counters. They can also be chained into one 16-bit counter, with the low counter as the least significant byte. One control/status byte holds the mode select, the two count-enable bits and two sticky overflow flags. Software reaches this byte and both counters through a small register bus with a write strobe and a combinational read.

A 3-bit power-state input changes how the block behaves:
- In some states counting goes on, but the overflow flags cannot be set.
- In some states the control byte is frozen.
- In module standby, counting stops completely.

To read a coherent value, software first clears the enable that gates the counter it wants to read: both enables in 8-bit mode, only the low enable in 16-bit mode.

The counter width `CW` must be at least 8, because the control byte uses bit positions 0 to 7.

Top module: `dual_event_counter`

## Requirements
- R1: After synchronous reset, the control byte, the low counter and the high counter all read 0.
- R2: In 8-bit mode (control bit 0 = 0), each valid event adds exactly 1 to the counter belonging to that pin, provided that counter's enable is set. The low enable is control bit 1 and the high enable is control bit 2. Events on a pin whose enable is clear are ignored.
- R3: In 8-bit mode, an increment from 0xFF to 0x00 sets a flag when flag updates are allowed. The low counter's wrap sets control bit 6 and the high counter's wrap sets control bit 7.
- R4: In 16-bit mode (control bit 0 = 1), the following rules apply:
  - The high counter increments only when the low counter steps from 0xFF to 0x00.
  - Events on the high pin are ignored.
  - The high enable has no effect.
  - Clearing the low enable stops the whole chain.
- R5: In 16-bit mode, a wrap of the full value from 0xFFFF to 0x0000 sets both control bit 7 and control bit 6 when flag updates are allowed. A low-byte-only wrap sets only bit 6.
- R6: A bus write of 0 to a flag bit clears that flag. A write of 1 leaves the flag unchanged. When hardware sets a flag in the same cycle as a clearing write, the set wins.
- R7: The power-state codes are: 0 active, 1 sleep, 2 watch, 3 subactive, 4 subsleep, 5 standby, 6 module standby. Code 7 behaves as active. In states 0, 1 and 3, counting, flag setting and control writes all work normally.
- R8: In states 2, 4 and 5, events still increment the counters, but no overflow flag is ever set.
- R9: In states 2, 4 and 5, bus writes to the control byte are ignored, including flag clears.
- R10: In state 6, events do not change either counter, and both counters keep their values. Control writes still take effect.
- R11: After synchronization, an event pin must hold its new level for `MIN_PULSE` consecutive clocks before the level is accepted. A high pulse shorter than this is ignored. Each accepted rising level counts exactly once.
- R12: The register map is as follows:
  - Address 0 is the control byte. Bits 5:3 always read 0.
  - Address 1 is the low counter. Address 2 is the high counter.
  - Address 3 reads 0.
  - A bus write to a counter loads that counter in any power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pmode | input | 3 | Power-state code |
| ev_lo_in | input | 1 | Asynchronous event pin for the low counter |
| ev_hi_in | input | 1 | Asynchronous event pin for the high counter |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data for the current address (combinational) |

## Verification
Most faults in the counter or control state reach `bus_rdata` on the next read. A missing or doubled increment shows up at once as a counter value off by one. A broken carry in 16-bit mode shows up as a high byte that stays unchanged across a low-byte wrap. Faults in the power-state decoding appear on the first event or control write after the state changes: a flag that should not be set becomes set, a frozen control byte accepts a write, or a halted counter still moves. A filter that is too short counts a narrow glitch. A filter that is too long drops an edge that should count, and the next read of the counter shows the error.

// File: rtl/evc_pkg.sv
package evc_pkg;

    typedef enum logic [2:0] {
        PM_ACTIVE  = 3'd0,
        PM_SLEEP   = 3'd1,
        PM_WATCH   = 3'd2,
        PM_SUBACT  = 3'd3,
        PM_SUBSLP  = 3'd4,
        PM_STANDBY = 3'd5,
        PM_MODSTBY = 3'd6,
        PM_RSVD    = 3'd7
    } pmode_e;

    typedef struct packed {
        logic run;       // events may move counters
        logic flag_upd;  // overflow flags may be set
        logic ctl_wr;    // control byte accepts writes
    } mode_cfg_t;

    typedef struct packed {
        logic ovf_hi;
        logic ovf_lo;
        logic en_hi;
        logic en_lo;
        logic chain;
    } ctl_t;

    localparam logic [1:0] ADDR_CTL = 2'd0;
    localparam logic [1:0] ADDR_LO  = 2'd1;
    localparam logic [1:0] ADDR_HI  = 2'd2;

    localparam int BIT_CHAIN  = 0;
    localparam int BIT_EN_LO  = 1;
    localparam int BIT_EN_HI  = 2;
    localparam int BIT_OVF_LO = 6;
    localparam int BIT_OVF_HI = 7;

    function automatic mode_cfg_t decode_mode(input pmode_e pm);
        mode_cfg_t c;
        case (pm)
            PM_WATCH, PM_SUBSLP, PM_STANDBY: c = '{run: 1'b1, flag_upd: 1'b0, ctl_wr: 1'b0};
            PM_MODSTBY:                      c = '{run: 1'b0, flag_upd: 1'b1, ctl_wr: 1'b1};
            default:                         c = '{run: 1'b1, flag_upd: 1'b1, ctl_wr: 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/evc_filter.sv
module evc_filter #(
    parameter int MIN_PULSE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int SW = $clog2(MIN_PULSE + 1);

    logic [1:0]    sync_q;
    logic          level_q;
    logic [SW-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '0;
            level_q <= 1'b0;
            stab_q  <= '0;
            rise    <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], din};
            rise   <= 1'b0;
            if (sync_q[1] == level_q) begin
                stab_q <= '0;
            end else if (stab_q == SW'(MIN_PULSE - 1)) begin
                level_q <= sync_q[1];
                stab_q  <= '0;
                rise    <= sync_q[1];
            end else begin
                stab_q <= stab_q + 1'b1;
            end
        end
    end

    AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise); // R11

endmodule

// File: rtl/evc_core.sv
module evc_core #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chain,
    input  logic          en_lo,
    input  logic          en_hi,
    input  logic          run,
    input  logic          ev_lo,
    input  logic          ev_hi,
    input  logic          lo_we,
    input  logic          hi_we,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] cnt_lo,
    output logic [CW-1:0] cnt_hi,
    output logic          wrap_lo,
    output logic          wrap_hi
);
    localparam logic [CW-1:0] CMAX = '1;

    logic inc_lo;
    logic inc_hi;

    always_comb begin
        inc_lo  = run && en_lo && ev_lo;
        wrap_lo = inc_lo && (cnt_lo == CMAX) && !lo_we;
        inc_hi  = chain ? wrap_lo : (run && en_hi && ev_hi);
        wrap_hi = inc_hi && (cnt_hi == CMAX) && !hi_we;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else begin
            if (lo_we)       cnt_lo <= wdata;
            else if (inc_lo) cnt_lo <= cnt_lo + 1'b1;
            if (hi_we)       cnt_hi <= wdata;
            else if (inc_hi) cnt_hi <= cnt_hi + 1'b1;
        end
    end

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !lo_we && !hi_we) |=> ($stable(cnt_lo) && $stable(cnt_hi))); // R10

    AST_CHAIN_CARRY: assert property (@(posedge clk) disable iff (rst)
        (chain && !hi_we && (cnt_lo != CMAX)) |=> $stable(cnt_hi)); // R4

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        !lo_we |=> (cnt_lo == $past(cnt_lo) || cnt_lo == $past(cnt_lo) + 1'b1)); // R2

endmodule

// File: rtl/dual_event_counter.sv
module dual_event_counter
    import evc_pkg::*;
#(
    parameter int CW        = 8,
    parameter int MIN_PULSE = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    pmode,
    input  logic          ev_lo_in,
    input  logic          ev_hi_in,
    input  logic [1:0]    bus_addr,
    input  logic          bus_we,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata
);
    mode_cfg_t     cfg;
    ctl_t          ctl_q;
    logic          ev_lo, ev_hi;
    logic          wrap_lo, wrap_hi;
    logic [CW-1:0] cnt_lo, cnt_hi;
    logic          ctl_we, lo_we, hi_we;

    always_comb begin
        cfg    = decode_mode(pmode_e'(pmode));
        ctl_we = bus_we && (bus_addr == ADDR_CTL) && cfg.ctl_wr;
        lo_we  = bus_we && (bus_addr == ADDR_LO);
        hi_we  = bus_we && (bus_addr == ADDR_HI);
    end

    evc_filter #(.MIN_PULSE(MIN_PULSE)) u_flt_lo (
        .clk(clk), .rst(rst), .din(ev_lo_in), .rise(ev_lo)
    );

    evc_filter #(.MIN_PULSE(MIN_PULSE)) u_flt_hi (
        .clk(clk), .rst(rst), .din(ev_hi_in), .rise(ev_hi)
    );

    evc_core #(.CW(CW)) u_core (
        .clk(clk), .rst(rst),
        .chain(ctl_q.chain), .en_lo(ctl_q.en_lo), .en_hi(ctl_q.en_hi),
        .run(cfg.run), .ev_lo(ev_lo), .ev_hi(ev_hi),
        .lo_we(lo_we), .hi_we(hi_we), .wdata(bus_wdata),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .wrap_lo(wrap_lo), .wrap_hi(wrap_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            if (ctl_we) begin
                ctl_q.chain  <= bus_wdata[BIT_CHAIN];
                ctl_q.en_lo  <= bus_wdata[BIT_EN_LO];
                ctl_q.en_hi  <= bus_wdata[BIT_EN_HI];
                ctl_q.ovf_lo <= ctl_q.ovf_lo && bus_wdata[BIT_OVF_LO];
                ctl_q.ovf_hi <= ctl_q.ovf_hi && bus_wdata[BIT_OVF_HI];
            end
            if (cfg.flag_upd && wrap_lo) ctl_q.ovf_lo <= 1'b1;
            if (cfg.flag_upd && wrap_hi) ctl_q.ovf_hi <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTL: begin
                bus_rdata[BIT_CHAIN]  = ctl_q.chain;
                bus_rdata[BIT_EN_LO]  = ctl_q.en_lo;
                bus_rdata[BIT_EN_HI]  = ctl_q.en_hi;
                bus_rdata[BIT_OVF_LO] = ctl_q.ovf_lo;
                bus_rdata[BIT_OVF_HI] = ctl_q.ovf_hi;
            end
            ADDR_LO: bus_rdata = cnt_lo;
            ADDR_HI: bus_rdata = cnt_hi;
            default: bus_rdata = '0;
        endcase
    end

    AST_CTL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !cfg.ctl_wr |=> $stable(ctl_q)); // R9

    AST_NO_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        !cfg.flag_upd |=> (!$rose(ctl_q.ovf_lo) && !$rose(ctl_q.ovf_hi))); // R8

    AST_W1_KEEP: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.ovf_hi && bus_we && bus_addr == ADDR_CTL && bus_wdata[BIT_OVF_HI]) |=> ctl_q.ovf_hi); // R6

    AST_FLAG_NEEDS_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!wrap_lo && !ctl_q.ovf_lo) |=> !ctl_q.ovf_lo); // R3

endmodule

// File: tb/dual_event_counter_tb.sv
`timescale 1ns/100ps
module dual_event_counter_tb;
    localparam int CW = 8;
    localparam int MP = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    pmode = 3'd0;
    logic          ev_lo_in = 1'b0, ev_hi_in = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic          bus_we = 1'b0;
    logic [CW-1:0] bus_wdata = '0;
    logic [CW-1:0] bus_rdata;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    dual_event_counter #(.CW(CW), .MIN_PULSE(MP)) u_dut (
        .clk(clk), .rst(rst), .pmode(pmode), .ev_lo_in(ev_lo_in), .ev_hi_in(ev_hi_in),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        n_chk++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr %0d actual %02h expected %02h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic pulse(input bit hi_pin, input int hw, input int lw);
        @(negedge clk);
        if (hi_pin) ev_hi_in = 1'b1; else ev_lo_in = 1'b1;
        cyc(hw);
        if (hi_pin) ev_hi_in = 1'b0; else ev_lo_in = 1'b0;
        cyc(lw);
    endtask

    task automatic ev(input bit hi_pin);
        pulse(hi_pin, 2 * MP, 2 * MP + 2);
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(2);
        chk("R1 ctl", 2'd0, 8'h00);
        chk("R1 lo", 2'd1, 8'h00);
        chk("R1 hi", 2'd2, 8'h00);
        chk("R12 addr3", 2'd3, 8'h00);

        // R2 independent 8-bit counting
        wr(2'd0, 8'h02);
        for (int i = 0; i < 3; i++) ev(1'b0);
        for (int i = 0; i < 2; i++) ev(1'b1);
        chk("R2 lo", 2'd1, 8'd3);
        chk("R2 hi disabled", 2'd2, 8'd0);
        wr(2'd0, 8'h06);
        for (int i = 0; i < 5; i++) ev(1'b1);
        chk("R2 hi", 2'd2, 8'd5);
        chk("R12 ctl", 2'd0, 8'h06);

        // R11 glitch rejection
        pulse(1'b0, 2, 12);
        pulse(1'b0, MP - 2, 12);
        chk("R11 glitch", 2'd1, 8'd3);
        pulse(1'b0, MP + 2, MP + 4);
        chk("R11 min width", 2'd1, 8'd4);

        // R3 wraps
        wr(2'd1, 8'hFF);
        chk("R12 load", 2'd1, 8'hFF);
        ev(1'b0);
        chk("R3 lo wrap", 2'd1, 8'h00);
        chk("R3 lo flag", 2'd0, 8'h46);
        wr(2'd2, 8'hFF);
        ev(1'b1);
        chk("R3 hi wrap", 2'd2, 8'h00);
        chk("R3 hi flag", 2'd0, 8'hC6);

        // R6 flag clearing
        wr(2'd0, 8'hC6);
        chk("R6 w1", 2'd0, 8'hC6);
        wr(2'd0, 8'h86);
        chk("R6 w0 lo", 2'd0, 8'h86);
        wr(2'd0, 8'h06);
        chk("R6 w0 hi", 2'd0, 8'h06);

        // R4 chaining
        wr(2'd0, 8'h03);
        wr(2'd2, 8'h12);
        wr(2'd1, 8'hFF);
        ev(1'b0);
        chk("R4 carry lo", 2'd1, 8'h00);
        chk("R4 carry hi", 2'd2, 8'h13);
        ev(1'b1);
        chk("R4 hi pin ignored", 2'd2, 8'h13);
        chk("R5 byte wrap flag", 2'd0, 8'h43);
        wr(2'd0, 8'h05);
        ev(1'b0);
        chk("R4 lo enable stops", 2'd1, 8'h00);

        // R5 full wrap
        wr(2'd0, 8'h03);
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'hFF);
        ev(1'b0);
        chk("R5 lo", 2'd1, 8'h00);
        chk("R5 hi", 2'd2, 8'h00);
        chk("R5 flags", 2'd0, 8'hC3);

        // R7 R8 R9 R10 sweep over all power states
        for (int pm = 0; pm < 8; pm++) begin
            bit run, flg, cw;
            run = (pm != 6);
            flg = !(pm == 2 || pm == 4 || pm == 5);
            cw  = flg;
            pmode = 3'd0;
            wr(2'd0, 8'h02);
            wr(2'd1, 8'hFF);
            wr(2'd2, 8'h40);
            @(negedge clk);
            pmode = 3'(pm);
            ev(1'b0);
            chk(pm == 6 ? "R10 halt lo" : (flg ? "R7 lo" : "R8 lo"), 2'd1, run ? 8'h00 : 8'hFF);
            chk(pm == 6 ? "R10 halt hi" : "R7 hi", 2'd2, 8'h40);
            chk(flg ? "R7 flag" : "R8 flag", 2'd0, (run && flg) ? 8'h42 : 8'h02);
            wr(2'd0, 8'h07);
            chk(cw ? "R7 ctl write" : "R9 ctl frozen", 2'd0,
                cw ? 8'h07 : ((run && flg) ? 8'h42 : 8'h02));
            wr(2'd1, 8'h5A);
            chk("R12 load any mode", 2'd1, 8'h5A);
        end
        pmode = 3'd0;

        // R8 chained full wrap in watch
        wr(2'd0, 8'h03);
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'hFF);
        @(negedge clk);
        pmode = 3'd2;
        ev(1'b0);
        chk("R8 chain lo", 2'd1, 8'h00);
        chk("R8 chain hi", 2'd2, 8'h00);
        chk("R8 chain flags", 2'd0, 8'h03);
        pmode = 3'd0;

        // R10 module standby with 16-bit mode
        wr(2'd1, 8'hFF);
        @(negedge clk);
        pmode = 3'd6;
        ev(1'b0);
        chk("R10 chain lo", 2'd1, 8'hFF);
        chk("R10 chain hi", 2'd2, 8'h00);
        pmode = 3'd0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule